// File: doc/BRIEF.md
# Self-Timed Sector Erase Engine with Polled Status

This block performs the erase step of a byte-wide flash model whose array is kept in registers and split into equal sectors. A command decoder hands it either a whole-array erase request or one or more sector erase requests. Sector requests are collected during a short acceptance window. Each new sector request restarts that window. When the window closes, the engine works through the array on its own. It first writes 0x00 into every targeted location (pre-program). It then writes 0xFF into every targeted location (erase). Each location costs a fixed number of clock cycles in each pass.

While the engine is busy, a read from an address inside a targeted sector returns a status byte instead of array data. Reads from any other address return the stored byte. Once the last location is erased, the engine drops busy and all reads return array contents again. A host load port fills the array for simulation. Locations untouched by an erase keep their contents, and so does the array after a reset. A reset in the middle of an erase therefore leaves the targeted sectors partly written.

Top module: `ee_erase_engine`

## Requirements
- R1: After reset `busy` is 0 and `rd_data` returns the stored byte at `rd_addr`. While idle, a load-port write (`wr_en`) stores `wr_data` at `wr_addr`.
- R2: A one-cycle `cmd_chip` pulse while idle starts pre-programming at once, with no window. Afterwards every location reads 0xFF. `busy` is high for exactly 2·N·STEP cycles, where N = SECTORS·2^WORD_BITS.
- R3: After a sector erase, every byte of the selected sectors reads 0xFF and every byte of the other sectors is unchanged.
- R4: Each `cmd_sector` pulse adds sector `cmd_sector_sel` to the target set and restarts a TIMEOUT-cycle window. The erase starts only when TIMEOUT cycles pass without a further sector command. `busy` stays high for TIMEOUT + 2·N·STEP cycles after the last sector command.
- R5: While busy, a read inside a targeted sector returns a status byte with bit 7 = 0. Bit 3 is 0 while the window is open and 1 once pre-program or erase has begun. All other bits are 0, so the byte is 0x00 or 0x08.
- R6: While busy, a read in a sector outside the target set returns the stored byte.
- R7: A `cmd_other` pulse during the window cancels the request. `busy` is 0 on the next cycle, no location changes, and no erase starts later.
- R8: `cmd_sector`, `cmd_other` and `cmd_chip` are ignored during pre-program and erase. The target set and the busy duration are unchanged.
- R9: Load-port writes are ignored while `busy` is 1.
- R10: A reset during the erase pass clears `busy` at once. Targeted locations the erase pass has already reached read 0xFF. The remaining targeted locations read 0x00 from the pre-program pass. Other sectors are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer (array contents are kept) |
| cmd_chip | input | 1 | One-cycle whole-array erase request |
| cmd_sector | input | 1 | One-cycle sector erase request |
| cmd_sector_sel | input | $clog2(SECTORS) | Sector number for `cmd_sector` |
| cmd_other | input | 1 | Any other command; cancels a request during the window |
| wr_en | input | 1 | Load-port write strobe |
| wr_addr | input | $clog2(SECTORS)+WORD_BITS | Load-port byte address |
| wr_data | input | 8 | Load-port byte |
| rd_addr | input | $clog2(SECTORS)+WORD_BITS | Read address |
| rd_data | output | 8 | Stored byte, or status byte while busy inside a targeted sector |
| busy | output | 1 | High from the accepted request until the last location is erased |

## Verification
On every cycle, assertions check the following:
- bit 7 of the read data stays low at any targeted address while the engine is busy;
- the window counter stays inside its limit;
- the erase pass never falls back to an earlier phase;
- a busy engine always has a non-empty target set;
- every array write lands at its address;
- a cancel during the window returns the engine to idle.

Only the bench scenarios can show the following:
- the exact busy lengths with and without window restarts;
- the final contents of the targeted and untargeted sectors;
- that commands and load writes are ignored during the passes;
- the 0xFF-then-0x00 split left behind by a reset during the erase pass.

// File: rtl/ee_pkg.sv
package ee_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_WINDOW  = 2'd1,
        PH_PREPROG = 2'd2,
        PH_ERASE   = 2'd3
    } ee_phase_e;

    localparam int STAT_POLL_BIT  = 7;
    localparam int STAT_TIMER_BIT = 3;
    localparam logic [7:0] ERASED_BYTE = 8'hFF;
    localparam logic [7:0] PREPROG_BYTE = 8'h00;
endpackage

// File: rtl/ee_sequencer.sv
module ee_sequencer
    import ee_pkg::*;
#(
    parameter int SECTORS   = 32,
    parameter int WORD_BITS = 2,
    parameter int STEP      = 3,
    parameter int TIMEOUT   = 20
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cmd_chip,
    input  logic                                   cmd_sector,
    input  logic [$clog2(SECTORS)-1:0]             cmd_sector_sel,
    input  logic                                   cmd_other,
    output logic                                   busy,
    output logic                                   erasing,
    output logic [SECTORS-1:0]                     target_mask,
    output logic                                   we,
    output logic [$clog2(SECTORS)+WORD_BITS-1:0]   waddr,
    output logic [7:0]                             wdata
);
    localparam int SECT_BITS = $clog2(SECTORS);
    localparam int ADDR_W    = SECT_BITS + WORD_BITS;
    localparam int STEP_W    = $clog2(STEP + 1);
    localparam int WIN_W     = $clog2(TIMEOUT + 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP - 1);
    localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(TIMEOUT - 1);
    localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

    typedef struct packed {
        ee_phase_e           phase;
        logic [SECTORS-1:0]  mask;
        logic [ADDR_W-1:0]   addr;
        logic [STEP_W-1:0]   step;
        logic [WIN_W-1:0]    win;
    } seq_state_t;

    seq_state_t q, d;
    logic [SECTORS-1:0] sel_bit;

    assign sel_bit = SECTORS'(1) << cmd_sector_sel;

    always_comb begin
        d     = q;
        we    = 1'b0;
        waddr = q.addr;
        wdata = (q.phase == PH_ERASE) ? ERASED_BYTE : PREPROG_BYTE;
        case (q.phase)
            PH_IDLE: begin
                if (cmd_chip) begin
                    d.phase = PH_PREPROG;
                    d.mask  = '1;
                    d.addr  = '0;
                    d.step  = '0;
                end else if (cmd_sector) begin
                    d.phase = PH_WINDOW;
                    d.mask  = sel_bit;
                    d.win   = '0;
                end
            end
            PH_WINDOW: begin
                if (cmd_sector) begin
                    d.mask = q.mask | sel_bit;
                    d.win  = '0;
                end else if (cmd_other || cmd_chip) begin
                    d.phase = PH_IDLE;
                    d.mask  = '0;
                end else if (q.win == WIN_LAST) begin
                    d.phase = PH_PREPROG;
                    d.addr  = '0;
                    d.step  = '0;
                end else begin
                    d.win = q.win + 1'b1;
                end
            end
            PH_PREPROG, PH_ERASE: begin
                if (q.step == STEP_LAST) begin
                    we     = q.mask[q.addr[ADDR_W-1:WORD_BITS]];
                    d.step = '0;
                    d.addr = q.addr + 1'b1;
                    if (q.addr == ADDR_LAST) begin
                        if (q.phase == PH_PREPROG) begin
                            d.phase = PH_ERASE;
                        end else begin
                            d.phase = PH_IDLE;
                            d.mask  = '0;
                        end
                    end
                end else begin
                    d.step = q.step + 1'b1;
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy        = (q.phase != PH_IDLE);
    assign erasing     = (q.phase == PH_PREPROG) || (q.phase == PH_ERASE);
    assign target_mask = q.mask;

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_WINDOW) |-> (q.win < WIN_W'(TIMEOUT))); // R4
    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_ERASE) |=> (q.phase == PH_ERASE || q.phase == PH_IDLE)); // R8
    AST_BUSY_HAS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q.mask != '0)); // R3
    AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_WINDOW && cmd_other && !cmd_sector) |=> !busy); // R7
endmodule

// File: rtl/ee_sector_bank.sv
module ee_sector_bank #(
    parameter int SECTORS   = 32,
    parameter int WORD_BITS = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   we,
    input  logic [$clog2(SECTORS)+WORD_BITS-1:0]   waddr,
    input  logic [7:0]                             wdata,
    input  logic [$clog2(SECTORS)+WORD_BITS-1:0]   raddr,
    output logic [7:0]                             rdata
);
    localparam int SECT_BITS = $clog2(SECTORS);
    localparam int ADDR_W    = SECT_BITS + WORD_BITS;
    localparam int SECT_WORDS = 1 << WORD_BITS;
    localparam int WORDS     = SECTORS * SECT_WORDS;

    logic [7:0] flat [WORDS];

    for (genvar s = 0; s < SECTORS; s++) begin : g_sector
        logic [7:0] words [SECT_WORDS];
        logic       hit;
        assign hit = we && (waddr[ADDR_W-1:WORD_BITS] == SECT_BITS'(s));
        always_ff @(posedge clk) begin
            if (hit) begin
                words[waddr[WORD_BITS-1:0]] <= wdata;
            end
        end
        for (genvar w = 0; w < SECT_WORDS; w++) begin : g_word
            assign flat[s*SECT_WORDS + w] = words[w];
        end
    end

    assign rdata = flat[raddr];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (flat[$past(waddr)] == $past(wdata))); // R2
endmodule

// File: rtl/ee_read_mux.sv
module ee_read_mux
    import ee_pkg::*;
#(
    parameter int SECTORS   = 32,
    parameter int WORD_BITS = 2
) (
    input  logic                                   busy,
    input  logic                                   erasing,
    input  logic [SECTORS-1:0]                     target_mask,
    input  logic [$clog2(SECTORS)+WORD_BITS-1:0]   raddr,
    input  logic [7:0]                             arr_data,
    output logic [7:0]                             rd_data
);
    localparam int ADDR_W = $clog2(SECTORS) + WORD_BITS;

    logic [7:0] status;
    logic       in_target;

    assign in_target = target_mask[raddr[ADDR_W-1:WORD_BITS]];

    always_comb begin
        status                 = 8'h00;
        status[STAT_POLL_BIT]  = 1'b0;
        status[STAT_TIMER_BIT] = erasing;
        rd_data = (busy && in_target) ? status : arr_data;
    end
endmodule

// File: rtl/ee_erase_engine.sv
module ee_erase_engine #(
    parameter int SECTORS   = 32,
    parameter int WORD_BITS = 2,
    parameter int STEP      = 3,
    parameter int TIMEOUT   = 20
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cmd_chip,
    input  logic                                   cmd_sector,
    input  logic [$clog2(SECTORS)-1:0]             cmd_sector_sel,
    input  logic                                   cmd_other,
    input  logic                                   wr_en,
    input  logic [$clog2(SECTORS)+WORD_BITS-1:0]   wr_addr,
    input  logic [7:0]                             wr_data,
    input  logic [$clog2(SECTORS)+WORD_BITS-1:0]   rd_addr,
    output logic [7:0]                             rd_data,
    output logic                                   busy
);
    localparam int ADDR_W = $clog2(SECTORS) + WORD_BITS;

    logic               seq_we, erasing, arr_we;
    logic [ADDR_W-1:0]  seq_waddr, arr_waddr;
    logic [7:0]         seq_wdata, arr_wdata, arr_rdata;
    logic [SECTORS-1:0] target_mask;

    ee_sequencer #(
        .SECTORS(SECTORS), .WORD_BITS(WORD_BITS), .STEP(STEP), .TIMEOUT(TIMEOUT)
    ) i_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_chip(cmd_chip), .cmd_sector(cmd_sector),
        .cmd_sector_sel(cmd_sector_sel), .cmd_other(cmd_other),
        .busy(busy), .erasing(erasing), .target_mask(target_mask),
        .we(seq_we), .waddr(seq_waddr), .wdata(seq_wdata)
    );

    assign arr_we    = seq_we || (wr_en && !busy);
    assign arr_waddr = seq_we ? seq_waddr : wr_addr;
    assign arr_wdata = seq_we ? seq_wdata : wr_data;

    ee_sector_bank #(
        .SECTORS(SECTORS), .WORD_BITS(WORD_BITS)
    ) i_bank (
        .clk(clk), .rst_n(rst_n),
        .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
        .raddr(rd_addr), .rdata(arr_rdata)
    );

    ee_read_mux #(
        .SECTORS(SECTORS), .WORD_BITS(WORD_BITS)
    ) i_mux (
        .busy(busy), .erasing(erasing), .target_mask(target_mask),
        .raddr(rd_addr), .arr_data(arr_rdata), .rd_data(rd_data)
    );

    AST_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && target_mask[rd_addr[ADDR_W-1:WORD_BITS]]) |-> !rd_data[7]); // R5
endmodule

// File: tb/test_ee_erase_engine.sv
`timescale 1ns/100ps
module test_ee_erase_engine;
    localparam int SECTORS = 32, WORD_BITS = 2, STEP = 3, TIMEOUT = 20;
    localparam int SB = $clog2(SECTORS);
    localparam int AW = SB + WORD_BITS;
    localparam int SW = 1 << WORD_BITS;
    localparam int N = SECTORS * SW;
    localparam int RUN = 2 * N * STEP;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, cmd_chip = 1'b0, cmd_sector = 1'b0, cmd_other = 1'b0, wr_en = 1'b0;
    logic [SB-1:0] cmd_sector_sel = '0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic busy;

    ee_erase_engine #(.SECTORS(SECTORS), .WORD_BITS(WORD_BITS), .STEP(STEP), .TIMEOUT(TIMEOUT))
    i_ee_erase_engine (
        .clk(clk), .rst_n(rst_n), .cmd_chip(cmd_chip), .cmd_sector(cmd_sector),
        .cmd_sector_sel(cmd_sector_sel), .cmd_other(cmd_other), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    logic [7:0] model [N];
    logic [SECTORS-1:0] tgt;
    int total = 0, bad = 0;

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] poll_exp(input bit started);
        return started ? 8'h08 : 8'h00;
    endfunction

    task automatic peek(input int a, output logic [7:0] v);
        rd_addr = AW'(a);
        #0.2;
        v = rd_data;
    endtask

    task automatic load_all();
        for (int a = 0; a < N; a++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = AW'(a); wr_data = 8'($urandom);
            model[a] = wr_data;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_all(input string req);
        logic [7:0] v;
        for (int a = 0; a < N; a++) begin
            peek(a, v);
            chk($sformatf("%s addr=%0d", req, a), v, model[a]);
        end
    endtask

    task automatic pulse_sector(input int s);
        @(negedge clk);
        cmd_sector = 1'b1; cmd_sector_sel = SB'(s); tgt[s] = 1'b1;
        @(negedge clk);
        cmd_sector = 1'b0;
    endtask

    task automatic apply_erase();
        for (int a = 0; a < N; a++) if (tgt[a / SW]) model[a] = 8'hFF;
        tgt = '0;
    endtask

    // Count busy cycles; probe status, outside reads and inject ignored stimulus.
    task automatic run_busy(output int n, input int t_addr, input int o_addr,
                            input bit win_first, input bit inject, input int inj_addr);
        logic [7:0] v;
        n = 0;
        while (busy && n < RUN + 4 * TIMEOUT) begin
            n++;
            if (t_addr >= 0 && n == 2) begin
                peek(t_addr, v);
                chk("R5 status at start", v, poll_exp(!win_first));
            end
            if (t_addr >= 0 && n == TIMEOUT + 4) begin
                peek(t_addr, v);
                chk("R5 status during pass", v, poll_exp(1'b1));
            end
            if (o_addr >= 0 && n == TIMEOUT + 7) begin
                peek(o_addr, v);
                chk("R6 outside read while busy", v, model[o_addr]);
            end
            if (inject && n == TIMEOUT + 10) begin
                cmd_sector = 1'b1; cmd_sector_sel = SB'(inj_addr / SW); cmd_other = 1'b1;
                cmd_chip = 1'b1; wr_en = 1'b1; wr_addr = AW'(inj_addr); wr_data = ~model[inj_addr];
            end else begin
                cmd_sector = 1'b0; cmd_other = 1'b0; cmd_chip = 1'b0; wr_en = 1'b0;
            end
            @(negedge clk);
        end
        cmd_sector = 1'b0; cmd_other = 1'b0; cmd_chip = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, o;
        logic [7:0] v;
        void'($urandom(32'd2024));
        tgt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        load_all();
        check_all("R1 idle read");

        // R2 chip erase, with ignored commands and load writes mid-pass (R8, R9)
        @(negedge clk); cmd_chip = 1'b1;
        @(negedge clk); cmd_chip = 1'b0;
        tgt = '1;
        run_busy(n, 5, -1, 1'b0, 1'b1, 10);
        chk("R2 chip busy cycles", n, RUN);
        apply_erase();
        check_all("R2 chip erased");

        // R4 window restart, R3 sector result, R8/R9 ignored commands to a non-target sector
        load_all();
        pulse_sector(3);
        repeat (TIMEOUT - 5) @(negedge clk);
        peek(3 * SW, v);
        chk("R4 still in window", v, poll_exp(1'b0));
        pulse_sector(17);
        run_busy(n, 17 * SW + 2, 8 * SW, 1'b1, 1'b1, 8 * SW + 1);
        chk("R4 busy after last sector command", n, TIMEOUT + RUN);
        apply_erase();
        check_all("R3 R9 sector erase");

        // R7 cancel during window
        pulse_sector(4);
        repeat (3) @(negedge clk);
        cmd_other = 1'b1;
        @(negedge clk); cmd_other = 1'b0;
        chk("R7 busy after cancel", busy, 0);
        repeat (TIMEOUT + 5) @(negedge clk);
        chk("R7 no later erase", busy, 0);
        tgt = '0;
        check_all("R7 array unchanged");

        // R10 reset in erase pass
        load_all();
        pulse_sector(0);
        pulse_sector(SECTORS - 1);
        repeat (TIMEOUT + N * STEP + N * STEP / 2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk); rst_n = 1'b1;
        #0.2;
        chk("R10 busy after reset", busy, 0);
        for (int a = 0; a < SW; a++) model[a] = 8'hFF;
        for (int a = (SECTORS - 1) * SW; a < N; a++) model[a] = 8'h00;
        tgt = '0;
        check_all("R10 partial erase");

        // Random sector erases
        for (int it = 0; it < 4; it++) begin
            int k, first;
            load_all();
            k = 1 + int'($urandom % 3);
            first = int'($urandom % SECTORS);
            pulse_sector(first);
            for (int j = 1; j < k; j++) begin
                repeat (int'($urandom % (TIMEOUT / 2))) @(negedge clk);
                pulse_sector(int'($urandom % SECTORS));
            end
            o = -1;
            for (int s = 0; s < SECTORS; s++) if (!tgt[s] && o < 0) o = s * SW;
            run_busy(n, first * SW, o, 1'b1, 1'b0, 0);
            chk("R4 random busy cycles", n, TIMEOUT + RUN);
            apply_erase();
            check_all("R3 random sector erase");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule